// File: doc/BRIEF.md
# Sticky Interrupt Mask and Status Register

This block is a 16-bit host-visible register that merges interrupt status and interrupt enables, and it drives one active-high interrupt line. Seven condition inputs come from the surrounding logic. Six of them are latched into status flags on a low-to-high transition of the condition. A host read of the register clears those flags. The seventh input is the FIFO service request. It is not latched: its status bit always mirrors the input as it is right now, so software can poll it.

Seven enable bits choose which status bits can reach the interrupt line. The interrupt line is a registered OR of the enabled status bits. The host reaches the register through a simple byte-addressed strobe interface. Only accesses that match the register's offset have any effect.

Top module: `irq_stat_reg`

## Requirements
- R1: After reset, `host_rdata` reads 0x0000 and `irq` is 0.
- R2: A latched status bit is set only by a 0-to-1 transition of its condition. While the condition is held high after the bit has been cleared, the bit stays 0.
- R3: A read at offset 0x0C clears every latched status bit. The latched bits and their conditions are: bit 0 stream error (cond_in[0]), bit 1 statistics ready (cond_in[1]), bit 2 last code (cond_in[2]), bit 4 FIFO stop (cond_in[4]), bit 5 FIFO error (cond_in[5]) and bit 6 memory error (cond_in[6]).
- R4: If a condition transition and a clearing read fall on the same clock edge, the bit is 1 after that edge.
- R5: Bit 3 always equals cond_in[3], the FIFO service request, in the same cycle. A read does not clear it.
- R6: A write at offset 0x0C loads host_wdata[14:8] into the enable bits [14:8]. Enable bit 8+i gates status bit i. Status bits ignore written values, and bits 7 and 15 always read 0.
- R7: `irq` is 1 in the cycle after an edge at which any status bit was 1 together with its enable bit. It is 0 one cycle after the last such pair is cleared or disabled.
- R8: Reads and writes at any other offset leave both the enable bits and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 8 | Byte offset of the host access |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; clears latched bits at the clock edge when the offset matches |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Register image, combinational |
| cond_in | input | 7 | Condition inputs, bit i feeds status bit i |
| irq | output | 1 | Registered interrupt output |

## Verification
The bench targets several corner cases, each of which a faulty design would show in a specific way:

- **Condition held high after a read.** A level-sensitive design would set the flag again at once.
- **Transition on the same edge as a clearing read.** A design that gives the clear priority would lose that event.
- **Read while the service request is high.** A design that treats bit 3 as latched would either clear it or hold it stale.
- **All 128 enable patterns against a full set of status bits.** This exposes any misplaced enable bit and any wrong interrupt latency.
- **Writes that carry ones in the status bits and reserved bits.** These must not set anything.
- **Accesses at neighbouring offsets.** These must neither clear nor write.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  parameter int N_COND   = 7;
  parameter int REG_W    = 16;
  parameter int MASK_LSB = 8;
  parameter int SRQ_BIT  = 3;
  // 1 = latched on rising edge, 0 = live level
  parameter logic [N_COND-1:0] LATCH_SEL = 7'b111_0111;

  typedef logic [N_COND-1:0] cond_vec_t;

  function automatic logic [REG_W-1:0] reg_image(cond_vec_t st, cond_vec_t en);
    logic [REG_W-1:0] w;
    w = '0;
    w[N_COND-1:0] = st;
    w[MASK_LSB +: N_COND] = en;
    return w;
  endfunction

  function automatic logic any_enabled(cond_vec_t st, cond_vec_t en);
    return |(st & en);
  endfunction

  function automatic logic latch_next(logic cur, logic rise, logic clr);
    return (clr ? 1'b0 : cur) | rise;
  endfunction
endpackage

// File: rtl/stat_capture.sv
module stat_capture
  import irq_stat_pkg::*;
#(
  parameter int                N   = N_COND,
  parameter logic [N-1:0]      SEL = LATCH_SEL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         clr,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] status_o
);
  logic [N-1:0] cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond;
  end

  assign rise_o = cond & ~cond_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (SEL[i]) begin : g_latch
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= latch_next(flag_q, rise_o[i], clr);
      end
      assign status_o[i] = flag_q;
    end else begin : g_live
      assign status_o[i] = cond[i];
    end
  end
endmodule

// File: rtl/enable_store.sv
module enable_store #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wfield,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_o <= '0;
    else if (we) en_o <= wfield;
  end
endmodule

// File: rtl/irq_reduce.sv
module irq_reduce
  import irq_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cond_vec_t status,
  input  cond_vec_t en,
  output logic      irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_enabled(status, en);
  end
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg
  import irq_stat_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic [N_COND-1:0] cond_in,
  output logic              irq
);
  logic      hit;
  logic      rd_hit;
  logic      wr_hit;
  cond_vec_t rise_vec;
  cond_vec_t status_vec;
  cond_vec_t en_vec;

  assign hit    = (host_addr == REG_OFFSET);
  assign rd_hit = hit & host_rd;
  assign wr_hit = hit & host_wr;

  stat_capture #(.N(N_COND), .SEL(LATCH_SEL)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond     (cond_in),
    .clr      (rd_hit),
    .rise_o   (rise_vec),
    .status_o (status_vec)
  );

  enable_store #(.N(N_COND)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_hit),
    .wfield (host_wdata[MASK_LSB +: N_COND]),
    .en_o   (en_vec)
  );

  irq_reduce u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_vec),
    .en     (en_vec),
    .irq_o  (irq)
  );

  assign host_rdata = reg_image(status_vec, en_vec);
endmodule

// File: rtl/irq_stat_reg_chk.sv
module irq_stat_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_hit,
  input logic        wr_hit,
  input logic [6:0]  rise_vec,
  input logic [6:0]  cond_in,
  input logic [15:0] host_wdata,
  input logic [15:0] host_rdata,
  input logic        irq
);
  localparam logic [6:0] LATCHED = 7'b111_0111;

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_vec & LATCHED)) |=>
      ((host_rdata[6:0] & $past(rise_vec) & LATCHED) == ($past(rise_vec) & LATCHED)));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> ((host_rdata[6:0] & LATCHED & ~$past(rise_vec)) == 7'd0));

  p_live_srq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[3] == cond_in[3]);

  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (host_rdata[15:8] == ($past(host_wdata[15:8]) & 8'h7F)));

  p_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !rd_hit && !(|rise_vec)) |=>
      (((host_rdata[7:0] ^ $past(host_rdata[7:0])) & 8'h77 & $past(host_wdata[7:0])) == 8'd0));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[7] == 1'b0) && (host_rdata[15] == 1'b0));

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|($past(host_rdata[6:0]) & $past(host_rdata[14:8])))));
endmodule

bind irq_stat_reg irq_stat_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_hit     (rd_hit),
  .wr_hit     (wr_hit),
  .rise_vec   (rise_vec),
  .cond_in    (cond_in),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .irq        (irq)
);

// File: tb/irq_stat_reg_bench.sv
`timescale 1ns/1ps
module irq_stat_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = 16'h0000;
  logic [15:0] host_rdata;
  logic [6:0]  cond_in = 7'd0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [6:0] m_latch = 7'd0;
  logic [6:0] m_en = 7'd0;
  logic [6:0] m_prev = 7'd0;
  logic       m_irq = 1'b0;

  always #4 clk = ~clk;

  irq_stat_reg u_irq_stat_reg (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cond_in(cond_in), .irq(irq)
  );

  function automatic logic [6:0] cur_status(logic [6:0] lat, logic [6:0] c);
    logic [6:0] s;
    s = lat & 7'h77;
    s[3] = c[3];
    return s;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [6:0] c, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [15:0] wd, input string tag);
    logic [6:0] st;
    logic [6:0] rise;
    logic       hit;
    @(negedge clk);
    cond_in = c; host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
    #1;
    st = cur_status(m_latch, c);
    check(host_rdata, {1'b0, m_en, 1'b0, st}, tag);
    check({15'd0, irq}, {15'd0, m_irq}, tag);
    @(posedge clk);
    hit  = (a == 8'h0C);
    rise = c & ~m_prev;
    m_irq   = |(st & m_en);
    m_latch = (((hit && rd) ? 7'd0 : m_latch) | rise) & 7'h77;
    if (hit && wr) m_en = wd[14:8];
    m_prev  = c;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(7'd0, 0, 0, 8'h00, 16'h0, "R1");
    step(7'd0, 0, 0, 8'h00, 16'h0, "R1");
    // R6 write all ones: enables load, status and reserved stay 0
    step(7'd0, 1, 0, 8'h0C, 16'hFFFF, "R6");
    step(7'd0, 0, 0, 8'h00, 16'h0, "R6");
    // R2/R3 per latched bit, R7 interrupt tracking
    for (int i = 0; i < 7; i++) begin
      if (i == 3) continue;
      step(7'd1 << i, 0, 0, 8'h00, 16'h0, "R2");
      step(7'd1 << i, 0, 0, 8'h00, 16'h0, "R7");
      step(7'd1 << i, 0, 1, 8'h0C, 16'h0, "R3");
      step(7'd1 << i, 0, 0, 8'h00, 16'h0, "R2");
      step(7'd1 << i, 0, 0, 8'h00, 16'h0, "R7");
      step(7'd0, 0, 0, 8'h00, 16'h0, "R2");
    end
    // R4 rise on the same edge as a clearing read
    step(7'b000_0010, 0, 1, 8'h0C, 16'h0, "R4");
    step(7'b000_0010, 0, 0, 8'h00, 16'h0, "R4");
    step(7'b000_0010, 0, 1, 8'h0C, 16'h0, "R3");
    step(7'd0, 0, 0, 8'h00, 16'h0, "R3");
    // R5 live service request, read does not clear
    step(7'b000_1000, 0, 0, 8'h00, 16'h0, "R5");
    step(7'b000_1000, 0, 1, 8'h0C, 16'h0, "R5");
    step(7'b000_1000, 0, 0, 8'h00, 16'h0, "R5");
    step(7'd0, 0, 0, 8'h00, 16'h0, "R5");
    step(7'd0, 0, 0, 8'h00, 16'h0, "R5");
    // R7 sweep all enable patterns with every status bit set
    step(7'h7F, 0, 0, 8'h00, 16'h0, "R7");
    for (int m = 0; m < 128; m++) begin
      step(7'h7F, 1, 0, 8'h0C, {1'b1, m[6:0], 8'hFF}, "R7");
      step(7'h7F, 0, 0, 8'h00, 16'h0, "R7");
    end
    // R8 other offsets: no clear, no write
    step(7'h7F, 0, 1, 8'h08, 16'h0, "R8");
    step(7'h7F, 1, 0, 8'h04, 16'h0000, "R8");
    step(7'h7F, 1, 1, 8'h0D, 16'h0000, "R8");
    step(7'h7F, 0, 0, 8'h00, 16'h0, "R8");
    // R7 disable then clear: irq drops one cycle later
    step(7'h7F, 1, 0, 8'h0C, 16'h0100, "R7");
    step(7'h7F, 0, 0, 8'h00, 16'h0, "R7");
    step(7'h77, 0, 1, 8'h0C, 16'h0, "R7");
    step(7'h00, 0, 0, 8'h00, 16'h0, "R7");
    step(7'h00, 0, 0, 8'h00, 16'h0, "R7");
    // R6 writing ones into status bits sets nothing
    step(7'h00, 1, 0, 8'h0C, 16'h7F7F, "R6");
    step(7'h00, 0, 0, 8'h00, 16'h0, "R6");
    step(7'h00, 0, 0, 8'h00, 16'h0, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule